// File: doc/BRIEF.md
# UART Transmitter with Half-Duplex Bus Driver Enable

This block serialises bytes onto a TXD line and, in the same clock domain, produces a driver-enable signal for a half-duplex differential transceiver. The enable is active only while a character is on the wire. Between transmissions it is released, so the shared pair is left to other nodes. The same line can also switch off the local receiver, which keeps the node from hearing its own characters.

Bytes arrive on a valid/ready interface and pass through a one-entry holding register, so the next byte can be queued while the current one is shifting. Bit timing comes from an external single-cycle baud tick, and every frame starts on a tick. Two static configuration inputs control the enable. One sets its active level. The other turns the driver-enable function on, or leaves the pin parked at its inactive level.

Top module: `uart_de_tx`

## Requirements
- R1: Each frame on txd_o is one start bit (0), then DATA_W data bits least significant bit first, then one stop bit (1). Each bit lasts from one baud tick to the next.
- R2: After reset, txd_o is 1, tx_ready_o is 1 and de_o is at its inactive level.
- R3: de_o reaches its active level in the same clock cycle in which the start bit first appears on txd_o.
- R4: de_o stays active until the baud tick that ends the stop bit of the last queued character, and goes inactive in the cycle after that tick. A lone frame keeps it active for exactly 10 tick intervals.
- R5: When a byte is waiting at the end of a stop bit, its start bit follows with no idle gap, and de_o stays active without a break across the frames.
- R6: With de_act_high_i = 1 the active level of de_o is 1. With de_act_high_i = 0 the active level is 0 and the idle level is 1.
- R7: With de_func_en_i = 0, de_o stays at its inactive level (the inverse of de_act_high_i) the whole time, and txd_o still transmits normally.
- R8: tx_ready_o is 1 exactly when the one-byte holding register is empty. A byte is taken on a clock edge where tx_valid_i and tx_ready_o are both 1. A held byte is not overwritten.
- R9: A frame starts only on a baud tick. A byte that arrives while the line is idle leaves txd_o high until the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Single-cycle pulse marking each bit boundary |
| de_func_en_i | input | 1 | 1: drive de_o during frames; 0: keep de_o inactive |
| de_act_high_i | input | 1 | Active level of de_o (1 = high, 0 = low) |
| tx_data_i | input | DATA_W | Byte to transmit |
| tx_valid_i | input | 1 | tx_data_i is valid |
| tx_ready_o | output | 1 | Holding register can take a byte |
| txd_o | output | 1 | Serial output, idles high |
| de_o | output | 1 | Transceiver driver/receiver enable |

## Verification
The bench checks that the enable rises in the same cycle as the start-bit falling edge. A design that registered the enable one stage late would clip the start bit on the bus. It measures how long the enable stays active on a lone frame and on a three-byte burst queued back to back. A release at the last data bit would cut off the stop bit, and a one-cycle drop between frames would show up as a shorter run. Each polarity setting and the disabled setting are exercised on live frames, so an inverted or ungated enable shows up at the pin. A byte offered mid-interval checks that the start bit waits for a tick and is not launched straight away with a shortened bit.

// File: rtl/uart_de_pkg.sv
package uart_de_pkg;
  localparam int unsigned STOP_BITS = 1;
  localparam int unsigned START_BITS = 1;

  typedef enum logic {
    DE_ACT_LOW  = 1'b0,
    DE_ACT_HIGH = 1'b1
  } de_level_e;
endpackage

// File: rtl/uart_de_hold.sv
module uart_de_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_vld_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_rdy_o,
  output logic              out_vld_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              take_i
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign in_rdy_o   = !full_q;
  assign out_vld_o  = full_q;
  assign out_data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (!full_q && in_vld_i) begin
      full_q <= 1'b1;
      data_q <= in_data_i;
    end else if (full_q && take_i) begin
      full_q <= 1'b0;
    end
  end

  assert_no_overwrite_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !take_i) |=> (full_q && $stable(data_q)));
endmodule

// File: rtl/uart_de_shift.sv
module uart_de_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ld_vld_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              ld_take_o,
  output logic              busy_o,
  output logic              txd_o
);
  import uart_de_pkg::*;

  localparam int unsigned FRAME_W = DATA_W + START_BITS + STOP_BITS;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               busy_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               at_end;

  assign at_end    = busy_q && (cnt_q == LAST);
  assign ld_take_o = tick_i && ld_vld_i && (!busy_q || at_end);
  assign busy_o    = busy_q;
  assign txd_o     = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (ld_take_o) begin
        // stop bits high, payload, start bit low at LSB
        sh_q   <= {{STOP_BITS{1'b1}}, ld_data_i, {START_BITS{1'b0}}};
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (at_end) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_bit_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i) |=> (busy_q && $stable(txd_o)));

  assert_start_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (txd_o == 1'b0));

  assert_stop_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(txd_o) == 1'b1 && $past(tick_i)));

  assert_tick_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(tick_i));
endmodule

// File: rtl/uart_de_drv.sv
module uart_de_drv (
  input  logic busy_i,
  input  logic fn_en_i,
  input  logic act_high_i,
  output logic de_o
);
  import uart_de_pkg::*;

  logic drive;
  assign drive = fn_en_i && busy_i;
  assign de_o  = (de_level_e'(act_high_i) == DE_ACT_HIGH) ? drive : !drive;
endmodule

// File: rtl/uart_de_tx.sv
module uart_de_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              de_func_en_i,
  input  logic              de_act_high_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              txd_o,
  output logic              de_o
);
  logic              hold_vld;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              busy;

  uart_de_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_vld_i  (tx_valid_i),
    .in_data_i (tx_data_i),
    .in_rdy_o  (tx_ready_o),
    .out_vld_o (hold_vld),
    .out_data_o(hold_data),
    .take_i    (take)
  );

  uart_de_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (baud_tick_i),
    .ld_vld_i (hold_vld),
    .ld_data_i(hold_data),
    .ld_take_o(take),
    .busy_o   (busy),
    .txd_o    (txd_o)
  );

  uart_de_drv u_drv (
    .busy_i    (busy),
    .fn_en_i   (de_func_en_i),
    .act_high_i(de_act_high_i),
    .de_o      (de_o)
  );

  assert_de_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && hold_vld && !baud_tick_i) |=> busy);
endmodule

// File: tb/sim_uart_de_tx.sv
module sim_uart_de_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic de_en = 1'b1;
  logic de_hi = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready, txd, de;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  uart_de_tx #(.DATA_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick),
    .de_func_en_i(de_en), .de_act_high_i(de_hi),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .txd_o(txd), .de_o(de)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // baud tick generator, driven at negedge
  int tick_div = 0;
  always @(negedge clk) begin
    tick_div = (tick_div + 1) % DIV;
    tick <= (tick_div == 0);
  end

  // reference model: queue of pending bytes, frame position by index
  byte unsigned q[$];
  bit m_busy = 0;
  int m_pos = 0;
  byte unsigned m_byte = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
      finish_run();
    end
    if (!rst_n) begin
      q.delete(); m_busy = 0; m_pos = 0;
    end else begin
      bit acc;
      acc = tx_valid && (q.size() == 0);
      if (tick) begin
        if (m_busy && m_pos < 9) m_pos++;
        else if (q.size() != 0) begin
          m_byte = q.pop_front(); m_busy = 1; m_pos = 0;
        end else m_busy = 0;
      end
      if (acc) q.push_back(tx_data);
    end
  end

  function automatic bit exp_txd();
    if (!m_busy || m_pos == 9) return 1'b1;
    if (m_pos == 0) return 1'b0;
    return m_byte[m_pos-1];
  endfunction

  function automatic bit exp_de();
    bit act;
    act = de_en && m_busy;
    return de_hi ? act : !act;
  endfunction

  // per-cycle compare plus run-length monitors
  bit prev_act = 0, prev_txd = 1;
  int run = 0, last_run = 0;
  int rise_cyc = -1, fall_cyc = -1;
  bit de_moved = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit act;
      check(txd == exp_txd(), "R1/R9 txd", txd, exp_txd());
      check(de == exp_de(), "R3/R6 de", de, exp_de());
      check(tx_ready == (q.size() == 0), "R8 ready", tx_ready, q.size() == 0);
      act = de_hi ? de : !de;
      if (act) run++;
      else if (prev_act) begin last_run = run; run = 0; end
      if (act && !prev_act) rise_cyc = cyc;
      if (!txd && prev_txd && rise_cyc >= 0 && fall_cyc < 0) fall_cyc = cyc;
      if (!de_en && act) de_moved = 1;
      prev_act = act; prev_txd = txd;
    end
  end

  task automatic send(input byte unsigned b);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    do begin @(negedge clk); guard++; end
    while ((m_busy || q.size() != 0 || tx_valid) && guard < 2000);
    repeat (2*DIV) @(negedge clk);
  endtask

  task automatic clear_mon();
    last_run = 0; rise_cyc = -1; fall_cyc = -1; de_moved = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(txd == 1'b1, "R2 txd idle", txd, 1);
    check(tx_ready == 1'b1, "R2 ready", tx_ready, 1);
    check(de == 1'b1, "R2 de inactive (active low)", de, 1);

    // single frame, active-low enable; offered mid-interval (R9)
    clear_mon();
    while (tick_div != 1) @(negedge clk);
    send(8'hA5);
    check(txd == 1'b1, "R9 no start before tick", txd, 1);
    wait_idle();
    check(last_run == 10*DIV, "R4 enable window", last_run, 10*DIV);
    check(rise_cyc == fall_cyc, "R3 enable with start bit", fall_cyc, rise_cyc);
    check(de == 1'b1, "R4 released after stop", de, 1);

    // back-to-back burst
    clear_mon();
    send(8'h00); send(8'hFF); send(8'h3C);
    wait_idle();
    check(last_run == 30*DIV, "R5 continuous enable", last_run, 30*DIV);

    // active-high polarity
    de_hi = 1'b1;
    @(negedge clk);
    check(de == 1'b0, "R6 idle level active-high", de, 0);
    clear_mon();
    send(8'h81);
    wait_idle();
    check(last_run == 10*DIV, "R6 active-high window", last_run, 10*DIV);

    // enable function off
    de_en = 1'b0; de_hi = 1'b0;
    clear_mon();
    send(8'h5A);
    wait_idle();
    check(de_moved == 1'b0, "R7 enable stays inactive", de_moved, 0);
    check(de == 1'b1, "R7 inactive level", de, 1);
    de_hi = 1'b1;
    clear_mon();
    send(8'hC3);
    wait_idle();
    check(de_moved == 1'b0, "R7 inactive active-high", de_moved, 0);

    finish_run();
  end
endmodule